// File: doc/BRIEF.md
# Board System Controller Registers

A memory-mapped register block for a board controller. It sits on a simple single-cycle write/read bus. Only the low 20 address bits are decoded, so the block repeats throughout any larger window it is given. A 256-byte hole, starting at offset 0x900, is left for an external UART and is never claimed by this block.

The block holds an 8-LED bar, a general-purpose output byte and an 8-character ASCII display buffer. The buffer can be loaded in two ways. A single 32-bit word write is expanded into eight uppercase hexadecimal characters. Per-character registers, spaced eight bytes apart, each store one byte. The block also provides a switch readback, bit-banged I2C controls (line levels, output enables, bus select and an input register that carries the live SDA level), and a one-cycle software reset request.

Top module: `board_ctl_regs`

## Requirements
- R1: Only `addr[19:0]` is decoded; an access whose upper address bits are nonzero behaves exactly like the access at the same low 20 bits.
- R2: The LED register (offset 0x008) keeps `wdata[7:0]`, drives `led`, reads back zero-extended and resets to 0x00.
- R3: A write to the word-display register (offset 0x010) sets display character k (k = 0..7) to the uppercase hex ASCII code of nibble `wdata[31-4k -: 4]`. Digits 0-9 map to 0x30-0x39 and 10-15 map to 0x41-0x46. Character k occupies `disp_text[8k+7:8k]`.
- R4: Offsets 0x418 + 8k (k = 0..7) are per-character registers: a write stores `wdata[7:0]` into character k, and a read returns that character zero-extended.
- R5: After reset, every display character is 0x20 (space).
- R6: The switch register (offset 0x000) always reads as zero.
- R7: A write to the I2C output register (offset 0xB10) drives `i2c_scl` from bit 1 and `i2c_sda` from bit 0. Both reset to 1, and a read returns {scl, sda} in bits 1:0.
- R8: The I2C output-enable register (0xB08) keeps 2 bits and the I2C select register (0xB18) keeps 1 bit. Both reset to zero and read back zero-extended.
- R9: The I2C input register (0xB00) reads as `{i2c_pins[7:1], i2c_sda_in}`. The `i2c_pins` value used is the one registered one cycle earlier, while `i2c_sda_in` is taken live in the read cycle.
- R10: A write to the software-reset register (0x100) raises `sys_rst_req` for exactly one cycle, in the cycle after the write.
- R11: A read of an offset that is neither a register nor inside the UART hole 0x900-0x9FF returns zero and pulses `bad_access` for one cycle. Reads inside the hole return zero with no flag. Writes to undefined offsets change nothing.
- R12: The general-purpose output register (0xA00) keeps `wdata[7:0]`, drives `gpio_out`, reads back and resets to zero.
- R13: Read data and `bad_access` appear in the cycle after `rd_en`, and `rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 32 | Byte address; low 20 bits decoded |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle pulse after a read of an undefined offset |
| led | output | 8 | LED bar |
| gpio_out | output | 8 | General-purpose output byte |
| disp_text | output | 64 | Display buffer, character k in bits 8k+7:8k |
| sys_rst_req | output | 1 | One-cycle software reset request |
| i2c_scl | output | 1 | Driven SCL level |
| i2c_sda | output | 1 | Driven SDA level |
| i2c_oe | output | 2 | I2C output enables |
| i2c_sel | output | 1 | I2C bus select |
| i2c_pins | input | 8 | Raw I2C input byte |
| i2c_sda_in | input | 1 | Live SDA level from the attached EEPROM |

## Verification
The assertions assume that reads and writes never arrive in the same cycle, and that both strobes are low throughout reset. Without these assumptions, a pulse or a stable output could be caused by a simultaneous access rather than by the logic under check. The bench drives exactly one strobe per access, on the falling edge. Every access lasts one cycle and is followed by an idle cycle, and the strobes stay low until reset has been released.

// File: rtl/board_ctl_regs.sv
module board_ctl_regs #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DEC_W   = 20,
  parameter int NCHAR   = 8,
  parameter int STEP_LG = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                bad_access,
  output logic [7:0]          led,
  output logic [7:0]          gpio_out,
  output logic [8*NCHAR-1:0]  disp_text,
  output logic                sys_rst_req,
  output logic                i2c_scl,
  output logic                i2c_sda,
  output logic [1:0]          i2c_oe,
  output logic                i2c_sel,
  input  logic [7:0]          i2c_pins,
  input  logic                i2c_sda_in
);
  localparam int IDXW = (NCHAR > 1) ? $clog2(NCHAR) : 1;
  localparam logic [DEC_W-1:0] OFS_SWITCH = DEC_W'('h000);
  localparam logic [DEC_W-1:0] OFS_LED    = DEC_W'('h008);
  localparam logic [DEC_W-1:0] OFS_WORD   = DEC_W'('h010);
  localparam logic [DEC_W-1:0] OFS_SOFTRS = DEC_W'('h100);
  localparam logic [DEC_W-1:0] OFS_CHAR0  = DEC_W'('h418);
  localparam logic [DEC_W-1:0] OFS_GAP    = DEC_W'('h900);
  localparam logic [DEC_W-1:0] OFS_GPOUT  = DEC_W'('hA00);
  localparam logic [DEC_W-1:0] OFS_I2CIN  = DEC_W'('hB00);
  localparam logic [DEC_W-1:0] OFS_I2COE  = DEC_W'('hB08);
  localparam logic [DEC_W-1:0] OFS_I2COUT = DEC_W'('hB10);
  localparam logic [DEC_W-1:0] OFS_I2CSEL = DEC_W'('hB18);
  localparam logic [DEC_W-1:0] CHAR_SPAN  = DEC_W'(NCHAR << STEP_LG);

  function automatic logic [7:0] hex_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  logic [DEC_W-1:0] ofs, rel;
  logic             char_hit, gap_hit;
  logic [IDXW-1:0]  cidx;
  logic [7:0]       disp [NCHAR];
  logic [7:0]       pins_q;
  logic [DATA_W-1:0] rd_val;
  logic             rd_hit;

  assign ofs      = addr[DEC_W-1:0];
  assign rel      = ofs - OFS_CHAR0;
  assign char_hit = (rel < CHAR_SPAN) && (rel[STEP_LG-1:0] == '0);
  assign cidx     = rel[STEP_LG +: IDXW];
  assign gap_hit  = (ofs[DEC_W-1:8] == OFS_GAP[DEC_W-1:8]);

  for (genvar k = 0; k < NCHAR; k++) begin : g_text
    assign disp_text[8*k +: 8] = disp[k];
  end

  always_comb begin
    rd_val = '0;
    rd_hit = 1'b1;
    case (ofs)
      OFS_SWITCH, OFS_WORD, OFS_SOFTRS: rd_val = '0;
      OFS_LED:    rd_val = DATA_W'(led);
      OFS_GPOUT:  rd_val = DATA_W'(gpio_out);
      OFS_I2CIN:  rd_val = DATA_W'({pins_q[7:1], i2c_sda_in});
      OFS_I2COE:  rd_val = DATA_W'(i2c_oe);
      OFS_I2COUT: rd_val = DATA_W'({i2c_scl, i2c_sda});
      OFS_I2CSEL: rd_val = DATA_W'(i2c_sel);
      default: begin
        if (char_hit)     rd_val = DATA_W'(disp[cidx]);
        else if (!gap_hit) rd_hit = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata       <= '0;
      bad_access  <= 1'b0;
      pins_q      <= '0;
    end else begin
      pins_q     <= i2c_pins;
      bad_access <= rd_en && !rd_hit;
      if (rd_en) rdata <= rd_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led         <= '0;
      gpio_out    <= '0;
      sys_rst_req <= 1'b0;
      i2c_scl     <= 1'b1;
      i2c_sda     <= 1'b1;
      i2c_oe      <= '0;
      i2c_sel     <= 1'b0;
      for (int k = 0; k < NCHAR; k++) disp[k] <= 8'h20;
    end else begin
      sys_rst_req <= wr_en && (ofs == OFS_SOFTRS);
      if (wr_en) begin
        case (ofs)
          OFS_LED:    led      <= wdata[7:0];
          OFS_GPOUT:  gpio_out <= wdata[7:0];
          OFS_I2COE:  i2c_oe   <= wdata[1:0];
          OFS_I2CSEL: i2c_sel  <= wdata[0];
          OFS_I2COUT: begin
            i2c_scl <= wdata[1];
            i2c_sda <= wdata[0];
          end
          OFS_WORD:
            for (int k = 0; k < NCHAR; k++)
              disp[k] <= hex_ascii(wdata[4*(NCHAR-1-k) +: 4]);
          default:
            if (char_hit) disp[cidx] <= wdata[7:0];
        endcase
      end
    end
  end

  assert_rst_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  assert_rst_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(wr_en));
  assert_bad_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(rd_en));
  assert_bad_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> rdata == '0);
  assert_led_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(led));
  assert_text_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(disp_text));
  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));
endmodule

// File: tb/board_ctl_regs_test.sv
module board_ctl_regs_test;
  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic        bad_access, sys_rst_req, i2c_scl, i2c_sda, i2c_sel, i2c_sda_in = 0;
  logic [7:0]  led, gpio_out, i2c_pins = '0;
  logic [63:0] disp_text;
  logic [1:0]  i2c_oe;
  int          n_run = 0, n_fail = 0;
  logic        done = 0;

  always #2 clk = ~clk;

  board_ctl_regs uut (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
    .bad_access, .led, .gpio_out, .disp_text, .sys_rst_req, .i2c_scl, .i2c_sda,
    .i2c_oe, .i2c_sel, .i2c_pins, .i2c_sda_in);

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d, output logic b);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata; b = bad_access;
    @(negedge clk);
  endtask

  function automatic logic [7:0] hx(input int n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  logic [31:0] d;
  logic        b;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R5 reset text", disp_text, {8{8'h20}});
    check("R2 reset led", led, 0);
    check("R12 reset gpio", gpio_out, 0);
    check("R7 reset scl/sda", {i2c_scl, i2c_sda}, 2'b11);
    check("R8 reset oe/sel", {i2c_oe, i2c_sel}, 0);
    check("R10 reset req", sys_rst_req, 0);
    check("R13 reset rdata", rdata, 0);

    rd(32'h000, d, b); check("R6 switch", {b, d}, 0);

    for (int v = 0; v < 256; v += 17) begin
      wr(32'h008, 32'hFFFF_FF00 | v);
      check("R2 led out", led, v);
      rd(32'h008, d, b); check("R2 led read", d, v);
      wr(32'hA00, 32'h1234_5600 | (255 - v));
      check("R12 gpio out", gpio_out, 255 - v);
      rd(32'hA00, d, b); check("R12 gpio read", d, 255 - v);
    end

    wr(32'hABC0_0008, 32'h5A);
    check("R1 alias write", led, 8'h5A);
    rd(32'h7770_0A00, d, b); check("R1 alias read", d, gpio_out);

    for (int p = 0; p < 8; p++)
      for (int n = 0; n < 16; n++) begin
        logic [31:0] w;
        w = 32'h0;
        for (int k = 0; k < 8; k++) w[4*(7-k) +: 4] = 4'((n + k * p) % 16);
        wr(32'h010, w);
        for (int k = 0; k < 8; k++)
          check("R3 hex char", disp_text[8*k +: 8], hx((n + k * p) % 16));
      end
    wr(32'h010, 32'h89AB_CDEF);
    for (int k = 0; k < 8; k++) begin
      rd(32'h418 + 8 * k, d, b);
      check("R3 R4 char readback", {b, d}, {1'b0, 24'h0, hx(8 + k)});
    end

    for (int k = 0; k < 8; k++) wr(32'h418 + 8 * k, 32'hFFFF_FF00 | (8'h61 + k));
    for (int k = 0; k < 8; k++) begin
      check("R4 char out", disp_text[8*k +: 8], 8'h61 + k);
      rd(32'h418 + 8 * k, d, b); check("R4 char read", d, 8'h61 + k);
    end

    for (int v = 0; v < 4; v++) begin
      wr(32'hB10, 32'hFC | v);
      check("R7 scl/sda", {i2c_scl, i2c_sda}, v);
      rd(32'hB10, d, b); check("R7 read", d, v);
      wr(32'hB08, 32'hFFFF_FFFC | v);
      check("R8 oe", i2c_oe, v);
      rd(32'hB08, d, b); check("R8 oe read", d, v);
      wr(32'hB18, 32'hFFFF_FFFE | (v & 1));
      check("R8 sel", i2c_sel, v & 1);
      rd(32'hB18, d, b); check("R8 sel read", d, v & 1);
    end

    for (int v = 0; v < 256; v += 51) begin
      i2c_pins = 8'(v); i2c_sda_in = ~v[0];
      rd(32'hB00, d, b);
      check("R9 i2c in", d, {v[7:1], ~v[0]});
    end

    wr(32'h100, 32'h1);
    check("R10 req high", sys_rst_req, 1);
    @(negedge clk);
    check("R10 req low", sys_rst_req, 0);

    rd(32'h008, d, b);
    foreach (d[i]) ;
    rd(32'h004, d, b); check("R11 bad misaligned", {b, d}, {1'b1, 32'h0});
    @(negedge clk);
    check("R11 bad one cycle", bad_access, 0);
    check("R13 rdata held", rdata, 0);
    rd(32'h41C, d, b); check("R11 bad char gap", {b, d}, {1'b1, 32'h0});
    rd(32'h458, d, b); check("R11 bad beyond chars", {b, d}, {1'b1, 32'h0});
    rd(32'hFFFF8, d, b); check("R11 bad top", {b, d}, {1'b1, 32'h0});
    rd(32'h900, d, b); check("R11 hole low", {b, d}, 0);
    rd(32'h9F8, d, b); check("R11 hole high", {b, d}, 0);
    wr(32'h458, 32'h7E); wr(32'h904, 32'h7E); wr(32'h00C, 32'h7E);
    for (int k = 0; k < 8; k++) begin
      rd(32'h418 + 8 * k, d, b); check("R11 ignored write", d, 8'h61 + k);
    end
    check("R11 led untouched", led, 8'h5A);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule